// File: doc/BRIEF.md
# Rotating Register Loop Controller

This block closes counted software-pipelined loops. It holds a trip counter and a drain counter, plus two independent rename offsets: one for the rotating slice of the general register file and one for the rotating slice of the predicate file. Each time the loop-closing branch executes, the block decides whether it is taken. It then steps the counters, shifts both offsets down by one, and returns the value to be written into the first stage predicate. Stage predicates set to 1 while the trip counter runs fill the software pipeline. Stage predicates set to 0 while the drain counter runs empty it. Because of this the compiler needs no separate prologue or epilogue code.

Two combinational lookup ports turn a virtual register number into a physical one. Inside a rotating region the physical number is the virtual number plus the region's offset, taken modulo the region size. Below the region the number passes through unchanged. The register files are outside this block.

Top module: `rot_loop_ctl`

## Requirements
- R1: After reset both offsets are 0, so every lookup returns its input, and both counters are 0, so a branch falls through with no stage write.
- R2: A general lookup with virtual number v in 32..127 returns 32 + ((v - 32 + grOffset) mod 96); after one rotation from reset, virtual 32 returns 127.
- R3: A predicate lookup with virtual number v in 16..63 returns 16 + ((v - 16 + prOffset) mod 48); after one rotation from reset, virtual 16 returns 63.
- R4: General numbers 0..31 and predicate numbers 0..15 are returned unchanged whatever the offsets hold.
- R5: A branch seen while the trip counter is nonzero is taken (taken=1), asserts stageWrEn with stageWrVal=1, and decrements the trip counter.
- R6: A branch seen with trip counter 0 and drain counter d>0 decrements the drain counter and asserts stageWrEn with stageWrVal=0; it is taken when d>1 and falls through when d=1.
- R7: A branch seen with both counters 0 falls through with stageWrEn=0 and leaves counters and offsets unchanged.
- R8: Every branch that is not idle per R7 lowers both offsets by one, modulo the region size, at the clock edge.
- R9: stageWrIdx is the physical predicate number of virtual 16 under the already-lowered predicate offset.
- R10: A counter load is visible to a branch one cycle later. A load in the same cycle as a branch wins over that branch's decrement, while that branch decides on the old values.
- R11: clearBases sets both offsets to 0 at the next edge, takes priority over rotation, and leaves the counters alone.
- R12: Starting from trip counter 3 and drain counter 2, five branches give taken four times and then a fall-through, leaving both offsets at -5 (general virtual 32 returns 123, predicate virtual 16 returns 59).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearBases | input | 1 | Zero both rename offsets |
| lcWrEn | input | 1 | Load the trip counter |
| lcWrData | input | LC_W | Trip counter load value |
| ecWrEn | input | 1 | Load the drain counter |
| ecWrData | input | EC_W | Drain counter load value |
| brExec | input | 1 | Loop-closing branch executes this cycle |
| grVirt | input | 7 | General register virtual number |
| grPhys | output | 7 | General register physical number |
| prVirt | input | 6 | Predicate virtual number |
| prPhys | output | 6 | Predicate physical number |
| taken | output | 1 | Branch decision, valid in the brExec cycle |
| stageWrEn | output | 1 | Write the first stage predicate |
| stageWrIdx | output | 6 | Physical predicate number to write |
| stageWrVal | output | 1 | Value for the stage predicate |

## Verification
The decision outputs taken, stageWrEn, stageWrVal and stageWrIdx are combinational. They are due in the same cycle as brExec and depend on the counters and offsets held before that cycle's edge. Counter loads, offset rotation and clears land at the next rising edge, so they first show at the lookup ports and in the next decision one cycle later. The bench drives each cycle's inputs just after the falling edge, samples 1 ns later while the held state is still the old one, and only then steps its reference model at the rising edge. Because of this ordering, every comparison pairs a result with the state that produced it.

// File: rtl/rot_loop_pkg.sv
package rot_loop_pkg;
  // strobes from branch control to the rename datapath
  typedef struct packed {
    logic rotate;    // branch is not idle: lower offsets, write stage predicate
    logic stageOne;  // value for the stage predicate
    logic taken;     // branch decision
  } rot_strobe_t;
endpackage

// File: rtl/rot_map.sv
module rot_map #(
  parameter int VW   = 7,
  parameter int LO   = 32,
  parameter int SIZE = 96,
  localparam int BW  = $clog2(SIZE)
) (
  input  logic [VW-1:0] virt,
  input  logic [BW-1:0] base,
  output logic [VW-1:0] phys
);
  logic [VW:0] offs, sum, wrapd;

  assign offs  = {1'b0, virt} - (VW+1)'(LO);
  assign sum   = offs + (VW+1)'(base);
  assign wrapd = (sum >= (VW+1)'(SIZE)) ? sum - (VW+1)'(SIZE) : sum;
  assign phys  = (virt < VW'(LO)) ? virt : VW'(wrapd + (VW+1)'(LO));

  // R2 R3 R4: a number never leaves the region it started in
  always_comb begin
    region_chk: assert ((virt < VW'(LO)) == (phys < VW'(LO)));
  end
endmodule

// File: rtl/rot_loop_ctrl.sv
module rot_loop_ctrl
  import rot_loop_pkg::*;
#(
  parameter int LC_W = 16,
  parameter int EC_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lcWrEn,
  input  logic [LC_W-1:0] lcWrData,
  input  logic            ecWrEn,
  input  logic [EC_W-1:0] ecWrData,
  input  logic            brExec,
  output rot_strobe_t     strobe
);
  logic [LC_W-1:0] loopCnt;
  logic [EC_W-1:0] epiCnt;
  logic loopLive, epiLive;

  assign loopLive = (loopCnt != '0);
  assign epiLive  = (epiCnt != '0);

  always_comb begin
    strobe.rotate   = brExec && (loopLive || epiLive);
    strobe.stageOne = loopLive;
    strobe.taken    = brExec && (loopLive || (epiCnt > EC_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loopCnt <= '0;
      epiCnt  <= '0;
    end else begin
      if (lcWrEn)                   loopCnt <= lcWrData;
      else if (brExec && loopLive)  loopCnt <= loopCnt - 1'b1;
      if (ecWrEn)                   epiCnt <= ecWrData;
      else if (brExec && !loopLive && epiLive) epiCnt <= epiCnt - 1'b1;
    end
  end

  // R5
  lc_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brExec && loopLive && !lcWrEn) |=> (loopCnt == $past(loopCnt) - 1'b1));
  // R6
  ec_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brExec && !loopLive && epiLive && !ecWrEn) |=> (epiCnt == $past(epiCnt) - 1'b1));
  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brExec && !loopLive && !epiLive && !lcWrEn && !ecWrEn) |=> (!loopLive && !epiLive));
  // R10
  lc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    lcWrEn |=> (loopCnt == $past(lcWrData)));
  // R10
  ec_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ecWrEn |=> (epiCnt == $past(ecWrData)));
endmodule

// File: rtl/rot_loop_dp.sv
module rot_loop_dp
  import rot_loop_pkg::*;
#(
  parameter int GR_REGS = 128,
  parameter int GR_LO   = 32,
  parameter int PR_REGS = 64,
  parameter int PR_LO   = 16,
  localparam int GR_VW   = $clog2(GR_REGS),
  localparam int PR_VW   = $clog2(PR_REGS),
  localparam int GR_SIZE = GR_REGS - GR_LO,
  localparam int PR_SIZE = PR_REGS - PR_LO,
  localparam int GR_BW   = $clog2(GR_SIZE),
  localparam int PR_BW   = $clog2(PR_SIZE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearBases,
  input  rot_strobe_t      strobe,
  input  logic [GR_VW-1:0] grVirt,
  output logic [GR_VW-1:0] grPhys,
  input  logic [PR_VW-1:0] prVirt,
  output logic [PR_VW-1:0] prPhys,
  output logic [PR_VW-1:0] stageWrIdx
);
  logic [GR_BW-1:0] grBase, grBaseNext;
  logic [PR_BW-1:0] prBase, prBaseNext;

  assign grBaseNext = (grBase == '0) ? GR_BW'(GR_SIZE - 1) : grBase - 1'b1;
  assign prBaseNext = (prBase == '0) ? PR_BW'(PR_SIZE - 1) : prBase - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || clearBases) begin
      grBase <= '0;
      prBase <= '0;
    end else if (strobe.rotate) begin
      grBase <= grBaseNext;
      prBase <= prBaseNext;
    end
  end

  rot_map #(.VW(GR_VW), .LO(GR_LO), .SIZE(GR_SIZE)) grMap (
    .virt(grVirt), .base(grBase), .phys(grPhys));
  rot_map #(.VW(PR_VW), .LO(PR_LO), .SIZE(PR_SIZE)) prMap (
    .virt(prVirt), .base(prBase), .phys(prPhys));
  rot_map #(.VW(PR_VW), .LO(PR_LO), .SIZE(PR_SIZE)) stageMap (
    .virt(PR_VW'(PR_LO)), .base(prBaseNext), .phys(stageWrIdx));

  // R8
  gr_rot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rotate && !clearBases) |=>
      (grBase == (($past(grBase) == '0) ? GR_BW'(GR_SIZE - 1) : $past(grBase) - 1'b1)));
  // R8
  pr_rot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rotate && !clearBases) |=>
      (prBase == (($past(prBase) == '0) ? PR_BW'(PR_SIZE - 1) : $past(prBase) - 1'b1)));
  // R11
  clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearBases |=> (grBase == '0 && prBase == '0));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rotate && !clearBases) |=> ($stable(grBase) && $stable(prBase)));
endmodule

// File: rtl/rot_loop_ctl.sv
module rot_loop_ctl
  import rot_loop_pkg::*;
#(
  parameter int LC_W    = 16,
  parameter int EC_W    = 8,
  parameter int GR_REGS = 128,
  parameter int GR_LO   = 32,
  parameter int PR_REGS = 64,
  parameter int PR_LO   = 16,
  localparam int GR_VW  = $clog2(GR_REGS),
  localparam int PR_VW  = $clog2(PR_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearBases,
  input  logic             lcWrEn,
  input  logic [LC_W-1:0]  lcWrData,
  input  logic             ecWrEn,
  input  logic [EC_W-1:0]  ecWrData,
  input  logic             brExec,
  input  logic [GR_VW-1:0] grVirt,
  output logic [GR_VW-1:0] grPhys,
  input  logic [PR_VW-1:0] prVirt,
  output logic [PR_VW-1:0] prPhys,
  output logic             taken,
  output logic             stageWrEn,
  output logic [PR_VW-1:0] stageWrIdx,
  output logic             stageWrVal
);
  rot_strobe_t strobe;

  rot_loop_ctrl #(.LC_W(LC_W), .EC_W(EC_W)) ctrl (
    .clk(clk), .rstN(rstN), .lcWrEn(lcWrEn), .lcWrData(lcWrData),
    .ecWrEn(ecWrEn), .ecWrData(ecWrData), .brExec(brExec), .strobe(strobe));

  rot_loop_dp #(.GR_REGS(GR_REGS), .GR_LO(GR_LO), .PR_REGS(PR_REGS), .PR_LO(PR_LO)) dp (
    .clk(clk), .rstN(rstN), .clearBases(clearBases), .strobe(strobe),
    .grVirt(grVirt), .grPhys(grPhys), .prVirt(prVirt), .prPhys(prPhys),
    .stageWrIdx(stageWrIdx));

  assign taken      = strobe.taken;
  assign stageWrEn  = strobe.rotate;
  assign stageWrVal = strobe.stageOne;

  // R5 R6: a taken branch always writes a stage predicate
  taken_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> stageWrEn);
endmodule

// File: tb/rot_loop_ctl_test.sv
module rot_loop_ctl_test;
  localparam int LC_W = 16;
  localparam int EC_W = 8;

  logic clk = 0, rstN = 0, clearBases = 0, lcWrEn = 0, ecWrEn = 0, brExec = 0;
  logic [LC_W-1:0] lcWrData = '0;
  logic [EC_W-1:0] ecWrData = '0;
  logic [6:0] grVirt = '0, grPhys;
  logic [5:0] prVirt = '0, prPhys, stageWrIdx;
  logic taken, stageWrEn, stageWrVal;

  int errors = 0, checks = 0;
  int mLc = 0, mEc = 0, mGb = 0, mPb = 0;
  int lastTaken = 0, lastWrEn = 0;

  always #2 clk = ~clk;

  rot_loop_ctl uut (.*);

  function automatic int mapNum(int v, int lo, int size, int base);
    if (v < lo) return v;
    return lo + ((v - lo + base) % size);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit b, bit lw, int ld, bit ew, int ed, bit clr, int gv, int pv);
    bit act, expTaken;
    int gvv, pvv;
    @(negedge clk);
    gvv = (gv < 0) ? int'($urandom_range(0, 127)) : gv;
    pvv = (pv < 0) ? int'($urandom_range(0, 63)) : pv;
    brExec = b; lcWrEn = lw; lcWrData = LC_W'(ld); ecWrEn = ew; ecWrData = EC_W'(ed);
    clearBases = clr; grVirt = 7'(gvv); prVirt = 6'(pvv);
    #1;
    act = b && (mLc != 0 || mEc != 0);
    expTaken = b && (mLc != 0 || mEc > 1);
    lastTaken = int'(taken); lastWrEn = int'(stageWrEn);
    chk(mLc != 0 ? "R5" : (mEc != 0 ? "R6" : "R7"), int'(taken), int'(expTaken));
    chk(mLc != 0 ? "R5" : (mEc != 0 ? "R6" : "R7"), int'(stageWrEn), int'(act));
    if (act) begin
      chk(mLc != 0 ? "R5" : "R6", int'(stageWrVal), int'(mLc != 0));
      chk("R9", int'(stageWrIdx), 16 + ((mPb + 47) % 48));
    end
    chk(gvv < 32 ? "R4" : "R2", int'(grPhys), mapNum(gvv, 32, 96, mGb));
    chk(pvv < 16 ? "R4" : "R3", int'(prPhys), mapNum(pvv, 16, 48, mPb));
    @(posedge clk);
    if (clr) begin mGb = 0; mPb = 0; end
    else if (act) begin mGb = (mGb + 95) % 96; mPb = (mPb + 47) % 48; end
    if (b && mLc == 0 && mEc != 0 && !ew) mEc = mEc - 1;
    if (lw) mLc = ld & 16'hFFFF; else if (b && mLc != 0) mLc = mLc - 1;
    if (ew) mEc = ed & 8'hFF;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; brExec = 0; lcWrEn = 0; ecWrEn = 0; clearBases = 0;
    repeat (2) @(posedge clk);
    mLc = 0; mEc = 0; mGb = 0; mPb = 0;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int takenCnt;
    void'($urandom(32'd4242));
    doReset();
    // R1: identity map and idle branch straight after reset
    step(0, 0, 0, 0, 0, 0, 40, 20);
    chk("R1", int'(grPhys), 40);
    chk("R1", int'(prPhys), 20);
    step(1, 0, 0, 0, 0, 0, -1, -1);
    chk("R1", lastTaken, 0);
    chk("R7", lastWrEn, 0);

    // R12: trip 3, drain 2
    step(0, 1, 3, 1, 2, 0, -1, -1);
    takenCnt = 0;
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 0, 0, 0, 0, -1, -1);
      takenCnt += lastTaken;
      if (i == 0) begin
        // R2 R3 wrap after one rotation: checked at next lookup
      end
    end
    chk("R12", takenCnt, 4);
    chk("R12", lastTaken, 0);
    step(0, 0, 0, 0, 0, 0, 32, 16);
    chk("R12", int'(grPhys), 123);
    chk("R12", int'(prPhys), 59);
    // R7: both counters spent, branch changes nothing
    step(1, 0, 0, 0, 0, 0, 32, 16);
    chk("R7", lastWrEn, 0);
    step(0, 0, 0, 0, 0, 0, 32, 16);
    chk("R7", int'(grPhys), 123);

    // R11: clear zeroes offsets
    step(0, 0, 0, 0, 0, 1, -1, -1);
    step(1, 1, 1, 0, 0, 0, 32, 16);
    // R10: load in a branch cycle; branch saw old zero counters
    chk("R10", lastTaken, 0);
    step(0, 0, 0, 0, 0, 0, 32, 16);
    chk("R11", int'(grPhys), 32);
    step(1, 0, 0, 0, 0, 0, -1, -1);
    chk("R10", lastTaken, 1);
    step(0, 0, 0, 0, 0, 0, 32, 16);
    chk("R8", int'(grPhys), 127);
    chk("R8", int'(prPhys), 63);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 9) < 6, $urandom_range(0, 9) == 0, $urandom_range(0, 5),
           $urandom_range(0, 9) == 0, $urandom_range(0, 3), $urandom_range(0, 31) == 0,
           -1, -1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule